// File: doc/BRIEF.md
# Two-Cycle Integer Multiplier for 32-bit Register Operands

This block executes the four 32-bit integer multiply operations of a simple in-order core: the low half of a product, and the high half of the product under three signedness treatments (signed by signed, unsigned by unsigned, signed first operand by unsigned second operand). The core's execute stage raises `start` for one cycle with the two operands and a 2-bit operation select. On that clock edge the block registers all three 64-bit products at once, whatever the operation. On the next edge it picks the requested half, loads it into the result register and pulses `resultValid`.

The control side is a two-state sequence: an idle state that accepts work and a select state that writes the result. `waitOut` is low in the cycle in which a request is accepted, because the select cycle always follows. The execute stage can therefore plan on a fixed latency instead of polling. `waitOut` is high only when a new `start` arrives during the select cycle. Such a request is not taken, and the requester must repeat it. The result register keeps its value until the next operation completes.

Top module: `mul_two_cycle`

## Requirements
- R1: With `opSel` = 2'b00 the completed result equals bits 31:0 of `srcA` × `srcB`.
- R2: With `opSel` = 2'b01 the completed result equals bits 63:32 of the product of `srcA` and `srcB`, both read as two's-complement signed.
- R3: With `opSel` = 2'b11 the completed result equals bits 63:32 of the product of `srcA` and `srcB`, both read as unsigned.
- R4: With `opSel` = 2'b10 the completed result equals bits 63:32 of the product of `srcA` read as signed and `srcB` read as unsigned.
- R5: A `start` sampled in the idle state on edge k makes `result` and `resultValid` = 1 visible after edge k+1. `resultValid` is high for exactly that one cycle.
- R6: `waitOut` is 0 in a cycle in which `start` is accepted from the idle state.
- R7: `result` keeps its value until the next operation completes, whatever `srcA`, `srcB` and `opSel` do meanwhile.
- R8: A `start` in the cycle right after an accepted `start` (the select cycle) drives `waitOut` = 1 in that cycle. That request is ignored and changes neither `result` nor `resultValid`.
- R9: After reset, `result` = 0, `resultValid` = 0 and `waitOut` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply this cycle |
| opSel | input | 2 | 00 low, 01 high signed×signed, 10 high signed×unsigned, 11 high unsigned×unsigned |
| srcA | input | 32 | First operand |
| srcB | input | 32 | Second operand |
| waitOut | output | 1 | High when a request arrives during the select cycle and is not taken |
| result | output | 32 | Selected half of the product, held until the next completion |
| resultValid | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The hardest situation to reach is the rejected request. It exists only in the one select cycle that follows an accepted start, so the stimulus holds `start` high for two cycles running and changes the operands and operation between them. It then checks that the second set has no effect on the result. The signed paths only show their difference at extreme operands, so the patterns include the most negative value, all ones and zero under every operation, alongside a long run of pseudo-random pairs. Idle gaps in which the operands keep changing show that the held result does not move.

// File: rtl/mul_two_cycle_pkg.sv
package mul_two_cycle_pkg;

  typedef enum logic [1:0] {
    OP_LOW     = 2'b00,
    OP_HIGH_SS = 2'b01,
    OP_HIGH_SU = 2'b10,
    OP_HIGH_UU = 2'b11
  } mulOp_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SELECT = 1'b1
  } mulState_e;

  typedef struct packed {
    logic capture;
    logic writeBack;
  } mulStrobe_t;

endpackage

// File: rtl/mul_two_cycle_ctrl.sv
module mul_two_cycle_ctrl
  import mul_two_cycle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       waitOut
);

  mulState_e state;
  mulState_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_SELECT;
      ST_SELECT: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign strobe.capture   = (state == ST_IDLE) && start;
  assign strobe.writeBack = (state == ST_SELECT);
  assign waitOut          = (state == ST_SELECT) && start;

  // The select state never lasts more than one cycle.
  assert_select_one_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SELECT) |=> (state == ST_IDLE));

  // An accepted request is followed by a write-back in the next cycle.
  assert_capture_then_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> strobe.writeBack);

  // A rejected request never leads to a second write-back.
  assert_reject_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    waitOut |=> !strobe.writeBack);

  // A request is never rejected and accepted in the same cycle.
  assert_accept_no_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !waitOut);

endmodule

// File: rtl/mul_two_cycle_dp.sv
module mul_two_cycle_dp
  import mul_two_cycle_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  mulStrobe_t      strobe,
  input  logic [1:0]      opSel,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] result,
  output logic            resultValid
);

  localparam int PROD_W = 2 * XLEN;
  localparam int EXT_W  = XLEN + 1;

  // Operands widened by one bit: sign or zero extension decides signedness.
  logic signed [EXT_W-1:0] aSigned, bSigned, aUnsigned, bUnsigned;
  assign aSigned   = {srcA[XLEN-1], srcA};
  assign bSigned   = {srcB[XLEN-1], srcB};
  assign aUnsigned = {1'b0, srcA};
  assign bUnsigned = {1'b0, srcB};

  logic signed [PROD_W-1:0] prodSs, prodUu, prodSu;
  assign prodSs = PROD_W'(aSigned) * PROD_W'(bSigned);
  assign prodUu = PROD_W'(aUnsigned) * PROD_W'(bUnsigned);
  assign prodSu = PROD_W'(aSigned) * PROD_W'(bUnsigned);

  logic [XLEN-1:0] highSsNext, highUuNext, highSuNext, lowNext;
  assign highSsNext = XLEN'(prodSs >>> XLEN);
  assign highUuNext = XLEN'(prodUu >>> XLEN);
  assign highSuNext = XLEN'(prodSu >>> XLEN);
  assign lowNext    = XLEN'(prodUu);

  // First cycle: register every variant together with the requested operation.
  logic [XLEN-1:0] highSsReg, highUuReg, highSuReg, lowReg;
  mulOp_e          opReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highSsReg <= '0;
      highUuReg <= '0;
      highSuReg <= '0;
      lowReg    <= '0;
      opReg     <= OP_LOW;
    end else if (strobe.capture) begin
      highSsReg <= highSsNext;
      highUuReg <= highUuNext;
      highSuReg <= highSuNext;
      lowReg    <= lowNext;
      opReg     <= mulOp_e'(opSel);
    end
  end

  // Second cycle: select the requested half.
  logic [XLEN-1:0] selected;
  always_comb begin
    unique case (opReg)
      OP_LOW:     selected = lowReg;
      OP_HIGH_SS: selected = highSsReg;
      OP_HIGH_SU: selected = highSuReg;
      OP_HIGH_UU: selected = highUuReg;
      default:    selected = lowReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.writeBack;
      if (strobe.writeBack) result <= selected;
    end
  end

  // The result changes only on a write-back.
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeBack |=> $stable(result));

  // The valid flag is a single-cycle pulse.
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // The operation register does not move between capture and write-back.
  assert_op_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeBack |-> !strobe.capture);

endmodule

// File: rtl/mul_two_cycle.sv
module mul_two_cycle
  import mul_two_cycle_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      opSel,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic            waitOut,
  output logic [XLEN-1:0] result,
  output logic            resultValid
);

  mulStrobe_t strobe;

  mul_two_cycle_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobe  (strobe),
    .waitOut (waitOut)
  );

  mul_two_cycle_dp #(.XLEN(XLEN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .opSel       (opSel),
    .srcA        (srcA),
    .srcB        (srcB),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: tb/mul_two_cycle_test.sv
`timescale 1ns/1ps
module mul_two_cycle_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] srcA = '0;
  logic [31:0] srcB = '0;
  logic        waitOut;
  logic [31:0] result;
  logic        resultValid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mul_two_cycle uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .waitOut(waitOut),
    .result(result), .resultValid(resultValid)
  );

  function automatic logic [31:0] refMul(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ub, pSigned;
    logic [63:0] pU;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ub = longint'({32'b0, b});
    pU = {32'b0, a} * {32'b0, b};
    case (op)
      2'b00: return pU[31:0];
      2'b01: begin pSigned = sa * sb; return pSigned[63:32]; end
      2'b10: begin pSigned = sa * ub; return pSigned[63:32]; end
      default: return pU[63:32];
    endcase
  endfunction

  function automatic string opTag(input logic [1:0] op);
    case (op)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b11: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Behavioural reference: busy flag plus a pending value.
  bit          mBusy = 0;
  logic [31:0] mPendVal = '0;
  logic [1:0]  mPendOp = 2'b00;
  logic [31:0] expResult = '0;
  bit          expValid = 0;
  string       lastTag = "R7";

  always @(posedge clk) begin
    if (rstN) begin
      if (mBusy) begin
        expResult = mPendVal;
        expValid  = 1;
        lastTag   = opTag(mPendOp);
        mBusy     = 0;
      end else begin
        expValid = 0;
        lastTag  = "R7";
        if (start) begin
          mBusy    = 1;
          mPendVal = refMul(opSel, srcA, srcB);
          mPendOp  = opSel;
        end
      end
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (result !== expResult) begin
        errors++;
        $display("FAIL %s result: actual=%h expected=%h", lastTag, result, expResult);
      end
      checks++;
      if (resultValid !== expValid) begin
        errors++;
        $display("FAIL R5 resultValid: actual=%b expected=%b", resultValid, expValid);
      end
      checks++;
      if (waitOut !== (mBusy && start)) begin
        errors++;
        $display("FAIL %s waitOut: actual=%b expected=%b", mBusy ? "R8" : "R6",
                 waitOut, mBusy && start);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input int gap);
    start = 1; opSel = op; srcA = a; srcB = b;
    @(negedge clk);
    start = 0; srcA = ~a; srcB = b ^ 32'h5a5a_5a5a; opSel = ~op;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  logic [31:0] lcg = 32'h1234_5678;
  function automatic logic [31:0] nextRand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    logic [31:0] corners [5];
    corners[0] = 32'h8000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h0000_0000; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h0000_0001;
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (result !== 32'h0 || resultValid !== 1'b0 || waitOut !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: actual=%h/%b/%b expected=0/0/0", result, resultValid, waitOut);
    end
    rstN = 1;
    @(negedge clk);
    // Corner operands under every operation (R1..R4)
    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          issue(2'(op), corners[i], corners[j], 1);
    // R8: back-to-back request is rejected, then R7: hold during idle gaps
    for (int k = 0; k < 20; k++) begin
      lcg = nextRand(lcg);
      start = 1; opSel = 2'(k); srcA = lcg; srcB = ~lcg;
      @(negedge clk);
      opSel = 2'(k + 1); srcA = lcg ^ 32'hFFFF_0000; srcB = 32'h8000_0000;
      @(negedge clk);
      start = 0;
      for (int g = 0; g < 3; g++) begin
        lcg = nextRand(lcg); srcA = lcg; srcB = lcg >> 3;
        @(negedge clk);
      end
    end
    // Pseudo-random operand pairs under all operations
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      lcg = nextRand(lcg); a = lcg;
      lcg = nextRand(lcg);
      issue(lcg[1:0], a, lcg, n % 3);
    end
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule